// File: doc/BRIEF.md
# Flash Command-Sequence Guard

This block is the command-state controller of a parallel NOR-style flash device whose write protection is always active. It watches bus write cycles (address, data, write strobe, output enable). The flash array can only be changed through a request that this block raises.

A byte program is released only after three correct unlock-and-command cycles, followed by the cycle that carries the target address and data. A sector or chip erase needs six correct cycles. A short strobe glitch does not count as a write, and neither does a strobe seen while output enable is held low. Any cycle that does not fit the expected sequence drops the controller straight back to array-read mode.

A separate command puts the device into an identification mode. In that mode the read mux selects fixed ID bytes instead of array data. After a request is issued, the block ignores the bus until the array reports completion.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset, `prog_req`, `erase_req` and `rd_sel_id` are all 0, and the block is in read mode.
- R2: A write counts only when `we_n` stays low (with `oe_n` high) for at least MIN_PULSE consecutive clock samples (default 2). A shorter pulse is ignored, and one long pulse counts as exactly one write.
- R3: While `oe_n` is low, a low `we_n` is never taken as a write.
- R4: The three cycles 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, followed by one more write, produce a one-cycle `prog_req`. The pulse comes in the cycle after that fourth write qualifies, and `prog_addr`/`prog_data` equal that write's address and data.
- R5: The six cycles 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, and then 0x30 to any address produce a one-cycle `erase_req` with `erase_kind`=0 (sector). `erase_addr` is the sixth address with its low SECT_W bits (default 12) cleared.
- R6: The same first five cycles followed by 0x10 to 0x5555 produce `erase_req` with `erase_kind`=1 (chip) and `erase_addr`=0. If 0x10 goes to any other address, no erase is issued.
- R7: A write outside a valid sequence never produces a request.
- R8: A wrong data byte or address at any step aborts the sequence. The block returns to read mode, which also clears identification mode, and a complete new sequence is needed.
- R9: Unlock addresses are compared on address bits [14:0] only, so higher bits are don't-care.
- R10: The three cycles 0xAA/0x5555, 0x55/0x2AAA and 0x90/0x5555 set `rd_sel_id`=1. In that mode, offset 0 reads `id_data`=0xBF, offset 1 reads 0x60, and any other offset reads 0x00.
- R11: In identification mode, either a single write of 0xF0 or the three-cycle sequence with command 0xF0 returns the block to read mode (`rd_sel_id`=0).
- R12: After a request, every write is ignored until `array_done` is sampled high. `prog_req` and `erase_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (19) | Bus address |
| bus_data | input | 8 | Bus write data |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| array_done | input | 1 | Array finished the current program or erase |
| prog_req | output | 1 | One-cycle byte-program request |
| prog_addr | output | ADDR_W (19) | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | One-cycle erase request |
| erase_kind | output | 1 | 0 = sector erase, 1 = chip erase |
| erase_addr | output | ADDR_W (19) | Sector base address (0 for chip erase) |
| rd_sel_id | output | 1 | Read mux selects ID bytes instead of array data |
| id_data | output | 8 | ID byte for the current address |

## Verification
A sequencer stuck in the wrong state shows up at the ports in one of three ways. A request pulse may be missing, a request may appear that nobody expected, or `rd_sel_id` may have the wrong level. Each of these is visible one clock after the qualifying edge of the write that should have decided the outcome. The scoreboard therefore pairs every request pulse with an expected item, and after each rejected or aborted sequence it confirms that nothing is left pending. A bad strobe qualifier shows up differently: a write is lost or counted twice, which shifts the whole sequence. The first symptom is then a missing or corrupted program request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int KEY_AW = 15;

    localparam logic [KEY_AW-1:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [KEY_AW-1:0] UNLOCK_ADDR_B = 15'h2AAA;
    localparam logic [7:0] UNLOCK_BYTE_A = 8'hAA;
    localparam logic [7:0] UNLOCK_BYTE_B = 8'h55;
    localparam logic [7:0] OP_PROGRAM    = 8'hA0;
    localparam logic [7:0] OP_ERASE_SET  = 8'h80;
    localparam logic [7:0] OP_SECTOR     = 8'h30;
    localparam logic [7:0] OP_CHIP       = 8'h10;
    localparam logic [7:0] OP_ID_ENTER   = 8'h90;

    typedef enum logic [2:0] {
        S_READ, S_UNL1, S_UNL2, S_PGM, S_ERS1, S_ERS2, S_ERS3, S_BUSY
    } seq_state_e;

    typedef enum logic {
        ERS_SECTOR = 1'b0,
        ERS_CHIP   = 1'b1
    } erase_kind_e;

    typedef struct packed {
        logic       at_a;     // low address bits hit the first unlock location
        logic       at_b;     // low address bits hit the second unlock location
        logic       key_a;    // first unlock byte at first location
        logic       key_b;    // second unlock byte at second location
        logic [7:0] data;
    } cyc_key_t;

    function automatic cyc_key_t make_key(input logic [KEY_AW-1:0] a,
                                          input logic [7:0] d);
        cyc_key_t k;
        k.at_a  = (a == UNLOCK_ADDR_A);
        k.at_b  = (a == UNLOCK_ADDR_B);
        k.key_a = k.at_a && (d == UNLOCK_BYTE_A);
        k.key_b = k.at_b && (d == UNLOCK_BYTE_B);
        k.data  = d;
        return k;
    endfunction

endpackage

// File: rtl/fcs_strobe_qual.sv
module fcs_strobe_qual #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic we_n,
    input  logic oe_n,
    output logic fire
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic [CNT_W-1:0] run_cnt;
    logic             active;

    assign active = !we_n && oe_n;
    assign fire   = active && (run_cnt == CNT_W'(MIN_PULSE - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            run_cnt <= '0;
        end else if (run_cnt < CNT_W'(MIN_PULSE)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fcs_id_mux.sv
module fcs_id_mux #(
    parameter int         ADDR_W = 19,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'h60
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        id_data
);
    always_comb begin
        if (addr[ADDR_W-1:1] != '0) begin
            id_data = 8'h00;
        end else begin
            id_data = addr[0] ? DEV_ID : MFR_ID;
        end
    end
endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              array_done,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_req,
    output erase_kind_e       erase_kind,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              id_mode
);
    seq_state_e  state, nxt;
    logic        nxt_id;
    logic        issue_p, issue_e;
    erase_kind_e kind_n;
    cyc_key_t    k;

    assign k = make_key(addr[KEY_AW-1:0], data);

    always_comb begin
        nxt     = state;
        nxt_id  = id_mode;
        issue_p = 1'b0;
        issue_e = 1'b0;
        kind_n  = ERS_SECTOR;
        if (state == S_BUSY) begin
            if (array_done) nxt = S_READ;
        end else if (fire) begin
            // any cycle not matched below aborts to read mode
            nxt    = S_READ;
            nxt_id = 1'b0;
            case (state)
                S_READ: if (k.key_a) begin nxt = S_UNL1; nxt_id = id_mode; end
                S_UNL1: if (k.key_b) begin nxt = S_UNL2; nxt_id = id_mode; end
                S_UNL2: if (k.at_a) begin
                    case (k.data)
                        OP_PROGRAM:   nxt = S_PGM;
                        OP_ERASE_SET: nxt = S_ERS1;
                        OP_ID_ENTER:  nxt_id = 1'b1;
                        default:      ;
                    endcase
                end
                S_PGM: begin
                    issue_p = 1'b1;
                    nxt     = S_BUSY;
                end
                S_ERS1: if (k.key_a) nxt = S_ERS2;
                S_ERS2: if (k.key_b) nxt = S_ERS3;
                S_ERS3: begin
                    if (k.data == OP_SECTOR) begin
                        issue_e = 1'b1;
                        nxt     = S_BUSY;
                    end else if (k.data == OP_CHIP && k.at_a) begin
                        issue_e = 1'b1;
                        kind_n  = ERS_CHIP;
                        nxt     = S_BUSY;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_READ;
            id_mode    <= 1'b0;
            prog_req   <= 1'b0;
            erase_req  <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_kind <= ERS_SECTOR;
            erase_addr <= '0;
        end else begin
            state     <= nxt;
            id_mode   <= nxt_id;
            prog_req  <= issue_p;
            erase_req <= issue_e;
            if (issue_p) begin
                prog_addr <= addr;
                prog_data <= data;
            end
            if (issue_e) begin
                erase_kind <= kind_n;
                erase_addr <= (kind_n == ERS_CHIP) ? '0
                            : {addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W    = 19,
    parameter int         SECT_W    = 12,
    parameter int         MIN_PULSE = 2,
    parameter logic [7:0] MFR_ID    = 8'hBF,
    parameter logic [7:0] DEV_ID    = 8'h60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              array_done,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_req,
    output logic              erase_kind,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              rd_sel_id,
    output logic [7:0]        id_data
);
    logic        wr_fire;
    erase_kind_e kind_q;

    fcs_strobe_qual #(.MIN_PULSE(MIN_PULSE)) qual_i (
        .clk (clk),
        .rst (rst),
        .we_n(we_n),
        .oe_n(oe_n),
        .fire(wr_fire)
    );

    fcs_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .fire      (wr_fire),
        .addr      (bus_addr),
        .data      (bus_data),
        .array_done(array_done),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .erase_req (erase_req),
        .erase_kind(kind_q),
        .erase_addr(erase_addr),
        .id_mode   (rd_sel_id)
    );

    assign erase_kind = kind_q;

    fcs_id_mux #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) idm_i (
        .addr   (bus_addr),
        .id_data(id_data)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_fire,
    input logic              array_done,
    input logic              prog_req,
    input logic              erase_req,
    input logic              erase_kind,
    input logic [ADDR_W-1:0] erase_addr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_sel_id,
    input logic [7:0]        id_data
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= (pending | prog_req | erase_req) & ~array_done;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!prog_req && !erase_req && !rd_sel_id));

    a_r2_single_fire: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> !wr_fire);

    a_r4_prog_one_cycle: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> !prog_req);

    a_r5_sector_aligned: assert property (@(posedge clk) disable iff (rst)
        (erase_req && !erase_kind) |-> (erase_addr[SECT_W-1:0] == '0));

    a_r6_chip_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (erase_req && erase_kind) |-> (erase_addr == '0));

    a_r10_mfr_byte: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_id && bus_addr == '0) |-> (id_data == 8'hBF));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(prog_req && erase_req));

    a_r12_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
        pending |-> (!prog_req && !erase_req));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .array_done(array_done),
    .prog_req  (prog_req),
    .erase_req (erase_req),
    .erase_kind(erase_kind),
    .erase_addr(erase_addr),
    .bus_addr  (bus_addr),
    .rd_sel_id (rd_sel_id),
    .id_data   (id_data)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 19;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int          kind;   // 0 program, 1 sector erase, 2 chip erase
        logic [AW-1:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_data = '0;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          array_done = 1'b0;
    logic          prog_req, erase_req, erase_kind, rd_sel_id;
    logic [AW-1:0] prog_addr, erase_addr;
    logic [7:0]    prog_data, id_data;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done_flag = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .we_n(we_n), .oe_n(oe_n), .array_done(array_done),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_req(erase_req), .erase_kind(erase_kind), .erase_addr(erase_addr),
        .rd_sel_id(rd_sel_id), .id_data(id_data)
    );

    // monitor: every request pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && (prog_req || erase_req)) begin
            int          k;
            logic [AW-1:0] a;
            logic [7:0]  d;
            k = prog_req ? 0 : (erase_kind ? 2 : 1);
            a = prog_req ? prog_addr : erase_addr;
            d = prog_req ? prog_data : 8'h00;
            n_vec++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected request (R7/R8/R12): kind=%0d addr=%h exp none", k, a);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (k != e.kind || a != e.addr || d != e.data) begin
                    n_bad++;
                    $display("FAIL %s: got kind=%0d addr=%h data=%h exp kind=%0d addr=%h data=%h",
                             e.tag, k, a, d, e.kind, e.addr, e.data);
                end
            end
        end
    end

    task automatic push_exp(input int kind, input logic [AW-1:0] a,
                            input logic [7:0] d, input string tag);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input int low = 2, input bit oe_low = 0);
        @(negedge clk);
        bus_addr = a; bus_data = d; we_n = 1'b0; oe_n = !oe_low;
        repeat (low) @(negedge clk);
        we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock(input logic [7:0] cmd);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, cmd);
    endtask

    task automatic pulse_done;
        @(negedge clk); array_done = 1'b1;
        @(negedge clk); array_done = 1'b0;
    endtask

    task automatic sb_drained(input string tag);
        repeat (3) @(negedge clk);
        check(tag, sb.size(), 0);
    endtask

    task automatic rd_id(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; oe_n = 1'b0;
        #1;
        check(tag, id_data, exp);
        oe_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got running exp finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 prog_req", prog_req, 0);
        check("R1 erase_req", erase_req, 0);
        check("R1 rd_sel_id", rd_sel_id, 0);

        // R4 basic program
        push_exp(0, 19'h12345, 8'h3C, "R4 program");
        unlock(8'hA0); wr(19'h12345, 8'h3C);
        pulse_done();
        sb_drained("R4 drained");

        // R7 plain write gives nothing
        wr(19'h00100, 8'h00); wr(19'h05555, 8'hA0);
        sb_drained("R7 plain write");

        // R8 abort on wrong second cycle; fresh sequence recovers
        wr(19'h05555, 8'hAA); wr(19'h01234, 8'h55); wr(19'h05555, 8'hA0);
        wr(19'h00222, 8'h77);
        sb_drained("R8 abort");
        push_exp(0, 19'h00333, 8'h11, "R8 recovery");
        unlock(8'hA0); wr(19'h00333, 8'h11);
        pulse_done();
        sb_drained("R8 recovered");

        // R9 upper address bits ignored on unlock
        push_exp(0, 19'h40010, 8'h5A, "R9 upper bits");
        wr(19'h7D555, 8'hAA); wr(19'h32AAA, 8'h55); wr(19'h45555, 8'hA0);
        wr(19'h40010, 8'h5A);
        pulse_done();
        sb_drained("R9 drained");

        // R2 glitch on data cycle ignored; full pulse then counts
        push_exp(0, 19'h00444, 8'hC3, "R2 after glitch");
        unlock(8'hA0);
        wr(19'h00999, 8'hEE, 1);
        wr(19'h00444, 8'hC3, 4);
        pulse_done();
        sb_drained("R2 drained");
        // R2 glitch on first unlock cycle breaks the sequence
        wr(19'h05555, 8'hAA, 1); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        wr(19'h00555, 8'h01);
        sb_drained("R2 glitch unlock");

        // R3 write with output enable low blocked
        push_exp(0, 19'h00666, 8'h66, "R3 oe block");
        unlock(8'hA0);
        wr(19'h00777, 8'h99, 3, 1);
        wr(19'h00666, 8'h66);
        pulse_done();
        sb_drained("R3 drained");

        // R5 sector erase
        push_exp(1, 19'h4A000, 8'h00, "R5 sector erase");
        unlock(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
        wr(19'h4A123, 8'h30);
        pulse_done();
        sb_drained("R5 drained");

        // R6 chip erase, and wrong address for chip command
        push_exp(2, 19'h00000, 8'h00, "R6 chip erase");
        unlock(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'h10);
        pulse_done();
        sb_drained("R6 drained");
        unlock(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
        wr(19'h01000, 8'h10);
        sb_drained("R6 bad address");

        // R12 busy: a full sequence before done is ignored
        push_exp(0, 19'h00888, 8'h88, "R12 first");
        unlock(8'hA0); wr(19'h00888, 8'h88);
        unlock(8'hA0); wr(19'h00889, 8'h89);
        sb_drained("R12 ignored while busy");
        pulse_done();
        push_exp(0, 19'h0088A, 8'h8A, "R12 after done");
        unlock(8'hA0); wr(19'h0088A, 8'h8A);
        pulse_done();
        sb_drained("R12 drained");

        // R10 identification mode
        unlock(8'h90);
        check("R10 sel", rd_sel_id, 1);
        rd_id(19'h00000, 8'hBF, "R10 mfr");
        rd_id(19'h00001, 8'h60, "R10 dev");
        rd_id(19'h00002, 8'h00, "R10 other");
        // R11 single-cycle exit
        wr(19'h00000, 8'hF0);
        check("R11 single exit", rd_sel_id, 0);
        // R11 three-cycle exit
        unlock(8'h90);
        check("R11 reenter", rd_sel_id, 1);
        unlock(8'hF0);
        check("R11 seq exit", rd_sel_id, 0);
        // R8 abort inside id mode returns to read mode
        unlock(8'h90);
        wr(19'h05555, 8'hAA); wr(19'h05555, 8'h00);
        check("R8 abort clears id", rd_sel_id, 0);

        repeat (5) @(negedge clk);
        while (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            n_bad++;
            $display("FAIL %s: got none exp addr=%h", e.tag, e.addr);
        end
        finish_run();
    end
endmodule